// File: doc/BRIEF.md
# S-record text loader

This block turns a stream of ASCII characters carrying S-record text into single-byte memory writes. Characters arrive one per cycle in which `in_valid` is high, and there is no back-pressure. The parser reads the record type digit, the byte count, the big-endian address and the data bytes. For every data byte of a loadable record it issues one write carrying the address and the byte value. It keeps a running sum of every byte after the type digit and checks the checksum at the end of each record.

Format faults raise a sticky error flag, and the parser then throws away the rest of the faulty line. A checksum fault raises a second flag, which covers only the most recent record. When a termination record arrives with a correct checksum, the parser captures its address as the entry point and raises `done`. After that, every later character is ignored until reset.

A boot-loader path places the block between a character source, such as a serial receiver, and a byte-wide memory write port.

Top module: `srec_loader`

## Requirements
- R1: After reset, `wr_valid`, `fmt_err`, `csum_err` and `done` are 0, and `entry_addr` is 0.
- R2: Outside a record, CR (0x0D) and LF (0x0A) are ignored and 'S' (0x53) opens a record. Any other character sets `fmt_err` and skips input up to the next CR or LF.
- R3: The character after 'S' must be a decimal digit other than '4'. It selects the address length: 2 bytes for types 0, 1, 5 and 9; 3 bytes for types 2, 6 and 8; 4 bytes for types 3 and 7. The digit '4' or a non-digit sets `fmt_err`.
- R4: Inside a record, only 0-9, A-F and a-f are accepted. Any other character sets `fmt_err` and produces no further writes from that line. If the offending character is itself CR or LF, it ends the line. Otherwise input is skipped up to the next CR or LF. The next record is then parsed normally.
- R5: For record types 1, 2 and 3, each data byte yields exactly one write. `wr_valid` is high for exactly the one cycle after the handshake that carries the byte's second hex digit. `wr_addr` is the record address plus the byte index, wrapping at 32 bits, and `wr_data` is the byte value. Hex digits are read high nibble first.
- R6: Record types 0, 5, 6, 7, 8 and 9 never produce writes.
- R7: A byte count smaller than the address length plus one sets `fmt_err`.
- R8: `csum_err` is set in the cycle after the last checksum digit if that byte differs from the inverted low byte of the sum of the count, address and data bytes. Writes already issued for the record stand. `csum_err` is cleared when the next 'S' is accepted.
- R9: A type 7, 8 or 9 record with a correct checksum sets `done` and loads `entry_addr` with its address, one cycle after the last checksum digit. Both then hold until reset, all further input is ignored, and a termination record with a bad checksum does not set `done`.
- R10: `fmt_err` stays set until reset.
- R11: A cycle with `in_valid` low changes no state and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present this cycle |
| in_char | input | 8 | ASCII character |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte write data |
| fmt_err | output | 1 | Sticky format error |
| csum_err | output | 1 | Checksum error of the latest record |
| done | output | 1 | Termination record accepted |
| entry_addr | output | 32 | Entry address from the termination record |

## Verification
Every result is registered once, so each write, each flag change and the entry address appear in the cycle that follows the handshake of the character that caused them. The bench drives one character at each falling edge and, in the same step, first compares the outputs against what its behavioural model predicted for the character driven one clock earlier. Idle cycles are compared in the same way, which catches strobes that are late, early or doubled. Scenario checks then compare write counts and flag values at the end of each sequence of records.

// File: rtl/srec_pkg.sv
`timescale 1ns/1ps
package srec_pkg;
    typedef enum logic [2:0] {
        P_IDLE = 3'd0,
        P_TYPE = 3'd1,
        P_CNT  = 3'd2,
        P_ADDR = 3'd3,
        P_DATA = 3'd4,
        P_CSUM = 3'd5,
        P_SKIP = 3'd6,
        P_DONE = 3'd7
    } phase_e;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned NIB_W  = 4;
endpackage

// File: rtl/srec_char_decode.sv
`timescale 1ns/1ps
module srec_char_decode
    import srec_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic [NIB_W-1:0]  nib,
    output logic              is_dig,
    output logic [NIB_W-1:0]  dig,
    output logic              is_eol,
    output logic              is_start
);
    always_comb begin
        is_hex   = 1'b0;
        nib      = '0;
        is_dig   = (ch >= 8'h30) && (ch <= 8'h39);
        dig      = ch[NIB_W-1:0];
        is_eol   = (ch == 8'h0D) || (ch == 8'h0A);
        is_start = (ch == 8'h53);
        if (is_dig) begin
            is_hex = 1'b1;
            nib    = ch[NIB_W-1:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            is_hex = 1'b1;
            nib    = ch[NIB_W-1:0] + 4'd9;
        end
    end
endmodule

// File: rtl/srec_type_map.sv
`timescale 1ns/1ps
module srec_type_map
    import srec_pkg::*;
#(
    parameter int unsigned ALEN_W = 3
) (
    input  logic [NIB_W-1:0]  rtype,
    output logic              legal,
    output logic [ALEN_W-1:0] alen,
    output logic              loads,
    output logic              term
);
    always_comb begin
        legal = 1'b1;
        case (rtype)
            4'd0, 4'd1, 4'd5, 4'd9: alen = ALEN_W'(2);
            4'd2, 4'd6, 4'd8:       alen = ALEN_W'(3);
            4'd3, 4'd7:             alen = ALEN_W'(4);
            default: begin
                alen  = ALEN_W'(2);
                legal = 1'b0;
            end
        endcase
        loads = (rtype >= 4'd1) && (rtype <= 4'd3);
        term  = (rtype >= 4'd7) && (rtype <= 4'd9);
    end
endmodule

// File: rtl/srec_loader.sv
`timescale 1ns/1ps
module srec_loader
    import srec_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              fmt_err,
    output logic              csum_err,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int unsigned BYTE_W = 2 * NIB_W;
    localparam int unsigned ALEN_W = 3;

    typedef struct packed {
        phase_e             ph;
        logic [NIB_W-1:0]   rtype;
        logic [ALEN_W-1:0]  alen;
        logic [ALEN_W-1:0]  aleft;
        logic [BYTE_W-1:0]  rem;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  sum;
        logic [NIB_W-1:0]   hi;
        logic               half;
        logic               wr_v;
        logic [ADDR_W-1:0]  wr_a;
        logic [BYTE_W-1:0]  wr_d;
        logic               ferr;
        logic               cerr;
        logic               done;
        logic [ADDR_W-1:0]  entry;
    } st_t;

    st_t s_d, s_q;

    logic              cd_hex, cd_dig, cd_eol, cd_start;
    logic [NIB_W-1:0]  cd_nib, cd_dig_v;
    logic [NIB_W-1:0]  tm_t;
    logic              tm_legal, tm_loads, tm_term;
    logic [ALEN_W-1:0] tm_alen;
    logic [BYTE_W-1:0] byte_v, sum_n, rem_n;

    srec_char_decode i_dec (
        .ch       (in_char),
        .is_hex   (cd_hex),
        .nib      (cd_nib),
        .is_dig   (cd_dig),
        .dig      (cd_dig_v),
        .is_eol   (cd_eol),
        .is_start (cd_start)
    );

    assign tm_t = (s_q.ph == P_TYPE) ? cd_dig_v : s_q.rtype;

    srec_type_map #(.ALEN_W(ALEN_W)) i_map (
        .rtype (tm_t),
        .legal (tm_legal),
        .alen  (tm_alen),
        .loads (tm_loads),
        .term  (tm_term)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wr_v = 1'b0;
        byte_v   = {s_q.hi, cd_nib};
        sum_n    = s_q.sum + byte_v;
        rem_n    = s_q.rem - BYTE_W'(1);
        if (in_valid) begin
            case (s_q.ph)
                P_DONE: ;
                P_SKIP: begin
                    if (cd_eol) s_d.ph = P_IDLE;
                end
                P_IDLE: begin
                    if (cd_start) begin
                        s_d.ph   = P_TYPE;
                        s_d.cerr = 1'b0;
                    end else if (!cd_eol) begin
                        s_d.ferr = 1'b1;
                        s_d.ph   = P_SKIP;
                    end
                end
                P_TYPE: begin
                    if (cd_dig && tm_legal) begin
                        s_d.rtype = cd_dig_v;
                        s_d.alen  = tm_alen;
                        s_d.half  = 1'b0;
                        s_d.addr  = '0;
                        s_d.ph    = P_CNT;
                    end else begin
                        s_d.ferr = 1'b1;
                        s_d.ph   = cd_eol ? P_IDLE : P_SKIP;
                    end
                end
                default: begin
                    if (!cd_hex) begin
                        s_d.ferr = 1'b1;
                        s_d.ph   = cd_eol ? P_IDLE : P_SKIP;
                    end else if (!s_q.half) begin
                        s_d.hi   = cd_nib;
                        s_d.half = 1'b1;
                    end else begin
                        s_d.half = 1'b0;
                        case (s_q.ph)
                            P_CNT: begin
                                s_d.rem   = byte_v;
                                s_d.sum   = byte_v;
                                s_d.aleft = s_q.alen;
                                if (byte_v < (BYTE_W'(s_q.alen) + BYTE_W'(1))) begin
                                    s_d.ferr = 1'b1;
                                    s_d.ph   = P_SKIP;
                                end else begin
                                    s_d.ph = P_ADDR;
                                end
                            end
                            P_ADDR: begin
                                s_d.addr  = {s_q.addr[ADDR_W-BYTE_W-1:0], byte_v};
                                s_d.sum   = sum_n;
                                s_d.rem   = rem_n;
                                s_d.aleft = s_q.aleft - ALEN_W'(1);
                                if (s_q.aleft == ALEN_W'(1))
                                    s_d.ph = (rem_n == BYTE_W'(1)) ? P_CSUM : P_DATA;
                            end
                            P_DATA: begin
                                if (tm_loads) begin
                                    s_d.wr_v = 1'b1;
                                    s_d.wr_a = s_q.addr;
                                    s_d.wr_d = byte_v;
                                    s_d.addr = s_q.addr + ADDR_W'(1);
                                end
                                s_d.sum = sum_n;
                                s_d.rem = rem_n;
                                if (rem_n == BYTE_W'(1)) s_d.ph = P_CSUM;
                            end
                            default: begin
                                s_d.ph = P_IDLE;
                                if (~s_q.sum != byte_v) begin
                                    s_d.cerr = 1'b1;
                                end else if (tm_term) begin
                                    s_d.done  = 1'b1;
                                    s_d.entry = s_q.addr;
                                    s_d.ph    = P_DONE;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid   = s_q.wr_v;
    assign wr_addr    = s_q.wr_a;
    assign wr_data    = s_q.wr_d;
    assign fmt_err    = s_q.ferr;
    assign csum_err   = s_q.cerr;
    assign done       = s_q.done;
    assign entry_addr = s_q.entry;

    // R5
    wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R5
    wr_after_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(in_valid));
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(entry_addr) && !wr_valid));
    // R10
    fmt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);
    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_valid && $stable(csum_err) && $stable(done)));
    // R8
    csum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csum_err) |-> $past(in_valid));
endmodule

// File: tb/test_srec_loader.sv
`timescale 1ns/1ps
module test_srec_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        fmt_err, csum_err, done;
    logic [31:0] entry_addr;

    srec_loader i_srec_loader (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .fmt_err(fmt_err), .csum_err(csum_err), .done(done), .entry_addr(entry_addr)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int wcnt = 0;

    // behavioural model state
    bit        m_done, m_ferr, m_cerr, m_skip, m_inrec, m_typed;
    bit [31:0] m_entry, m_addr;
    int        m_typ, m_alen, m_cnt, m_sum;
    int        nq[$];
    bit        exp_wr;
    bit [31:0] exp_wa;
    bit [7:0]  exp_wd;

    task automatic chk(string tag, longint got, longint expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, expv);
        end
    endtask

    task automatic model_reset();
        m_done = 0; m_ferr = 0; m_cerr = 0; m_skip = 0; m_inrec = 0; m_typed = 0;
        m_entry = 0; m_addr = 0; exp_wr = 0; nq.delete();
    endtask

    task automatic model_bad(bit eol);
        m_ferr = 1; m_inrec = 0; m_skip = !eol;
    endtask

    task automatic model(byte unsigned c);
        bit eol, hex;
        int v, b, k;
        exp_wr = 0;
        if (m_done) return;
        eol = (c == 8'h0D) || (c == 8'h0A);
        hex = 1; v = 0;
        if (c >= "0" && c <= "9") v = c - "0";
        else if (c >= "A" && c <= "F") v = c - "A" + 10;
        else if (c >= "a" && c <= "f") v = c - "a" + 10;
        else hex = 0;
        if (m_skip) begin
            if (eol) m_skip = 0;
            return;
        end
        if (!m_inrec) begin
            if (c == "S") begin
                m_inrec = 1; m_typed = 0; nq.delete(); m_cerr = 0;
            end else if (!eol) begin
                m_ferr = 1; m_skip = 1;
            end
            return;
        end
        if (!m_typed) begin
            if (c >= "0" && c <= "9" && c != "4") begin
                m_typed = 1; m_typ = c - "0"; m_addr = 0;
                if (m_typ == 3 || m_typ == 7) m_alen = 4;
                else if (m_typ == 2 || m_typ == 6 || m_typ == 8) m_alen = 3;
                else m_alen = 2;
            end else model_bad(eol);
            return;
        end
        if (!hex) begin
            model_bad(eol);
            return;
        end
        nq.push_back(v);
        if (nq.size() % 2 != 0) return;
        b = nq[nq.size()-2] * 16 + nq[nq.size()-1];
        k = nq.size() / 2 - 1;
        if (k == 0) begin
            m_cnt = b; m_sum = b;
            if (m_cnt < m_alen + 1) model_bad(0);
        end else if (k <= m_alen) begin
            m_addr = {m_addr[23:0], 8'(b)};
            m_sum += b;
        end else if (k < m_cnt) begin
            if (m_typ >= 1 && m_typ <= 3) begin
                exp_wr = 1; exp_wa = m_addr + 32'(k - m_alen - 1); exp_wd = 8'(b);
            end
            m_sum += b;
        end else begin
            m_inrec = 0;
            if (((~m_sum) & 255) != b) m_cerr = 1;
            else if (m_typ >= 7) begin
                m_done = 1; m_entry = m_addr;
            end
        end
    endtask

    task automatic compare();
        chk("R5 wr_valid", wr_valid, exp_wr);
        if (wr_valid) wcnt++;
        if (exp_wr && wr_valid) begin
            chk("R5 wr_addr", wr_addr, exp_wa);
            chk("R5 wr_data", wr_data, exp_wd);
        end
        chk("R10 fmt_err", fmt_err, m_ferr);
        chk("R8 csum_err", csum_err, m_cerr);
        chk("R9 done", done, m_done);
        if (m_done) chk("R9 entry_addr", entry_addr, m_entry);
    endtask

    task automatic tick(bit v, byte unsigned c);
        @(negedge clk);
        compare();
        in_valid = v;
        in_char  = c;
        if (v) model(c);
        else exp_wr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
        wcnt = 0;
        tick(0, 8'h00);
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 fmt_err", fmt_err, 0);
        chk("R1 csum_err", csum_err, 0);
        chk("R1 done", done, 0);
        chk("R1 entry_addr", entry_addr, 0);
    endtask

    task automatic send(string s, bit gap);
        for (int i = 0; i < s.len(); i++) begin
            tick(1, s[i]);
            if (gap && (i % 3 == 2)) begin
                tick(0, "Z");
                tick(0, "G");
            end
        end
    endtask

    function automatic string mk(int t, bit [31:0] a, byte unsigned d[$], bit lc, bit corrupt);
        int al, cnt, sum;
        string s, f;
        f = lc ? "%02x" : "%02X";
        al = (t == 3 || t == 7) ? 4 : ((t == 2 || t == 6 || t == 8) ? 3 : 2);
        cnt = al + d.size() + 1;
        sum = cnt;
        s = $sformatf("S%0d", t);
        s = {s, $sformatf(f, cnt)};
        for (int i = al - 1; i >= 0; i--) begin
            s = {s, $sformatf(f, a[i*8 +: 8])};
            sum += a[i*8 +: 8];
        end
        foreach (d[i]) begin
            s = {s, $sformatf(f, d[i])};
            sum += d[i];
        end
        sum = (~sum) & 255;
        if (corrupt) sum = sum ^ 1;
        s = {s, $sformatf(f, sum)};
        return $sformatf("%s%c%c", s, 8'd13, 8'd10);
    endfunction

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string crlf;
        crlf = $sformatf("%c%c", 8'd13, 8'd10);

        // scenario: loadable records, address widths, wrap, non-loading types
        do_reset();
        send(crlf, 0);
        chk("R2 crlf ignored", fmt_err, 0);
        send(mk(1, 32'h1000, '{8'hAA, 8'hBB, 8'hCC, 8'hDD}, 0, 0), 0);
        send(mk(2, 32'h123456, '{8'h0B, 8'h16, 8'hEF}, 1, 0), 0);
        send(mk(3, 32'hFFFFFFFF, '{8'h01, 8'h02}, 0, 0), 0);
        tick(0, 0);
        chk("R5 writes from S1 S2 S3", wcnt, 9);
        chk("R3 legal types no error", fmt_err, 0);
        send(mk(0, 32'h0, '{8'h68, 8'h69}, 0, 0), 0);
        send(mk(5, 32'h3, '{}, 0, 0), 0);
        send(mk(6, 32'h3, '{8'h11}, 0, 0), 0);
        tick(0, 0);
        chk("R6 no writes from S0 S5 S6", wcnt, 9);
        send(mk(1, 32'h0200, '{8'h5A, 8'hA5}, 0, 0), 1);
        tick(0, 0);
        chk("R11 gaps ignored writes", wcnt, 11);
        chk("R11 gaps ignored fmt", fmt_err, 0);
        send(mk(9, 32'h2000, '{}, 0, 0), 0);
        tick(0, 0);
        chk("R9 done", done, 1);
        chk("R9 entry", entry_addr, 32'h2000);
        send(mk(1, 32'h0, '{8'h01}, 0, 0), 0);
        send("qq", 0);
        tick(0, 0);
        chk("R9 input ignored after done", wcnt, 11);
        chk("R9 no fmt after done", fmt_err, 0);

        // scenario: checksum failure
        do_reset();
        send(mk(1, 32'h40, '{8'h05, 8'h06}, 0, 1), 0);
        tick(0, 0);
        chk("R8 csum_err set", csum_err, 1);
        chk("R8 writes kept", wcnt, 2);
        send(mk(1, 32'h50, '{8'h07}, 0, 0), 0);
        tick(0, 0);
        chk("R8 csum_err cleared", csum_err, 0);

        // scenario: illegal type digit, then recovery
        do_reset();
        send({"S4030000FC", crlf}, 0);
        tick(0, 0);
        chk("R3 type 4 rejected", fmt_err, 1);
        send(mk(1, 32'h10, '{8'h09}, 0, 0), 0);
        tick(0, 0);
        chk("R4 next line parsed", wcnt, 1);
        chk("R10 fmt_err sticky", fmt_err, 1);

        // scenario: bad character inside data
        do_reset();
        send({"S1051000AAGBB", crlf}, 0);
        send({"S1", crlf}, 0);
        tick(0, 0);
        chk("R4 writes stop at bad char", wcnt, 1);
        chk("R4 fmt_err", fmt_err, 1);

        // scenario: count too small
        do_reset();
        send({"S1020000FD", crlf}, 0);
        tick(0, 0);
        chk("R7 short count", fmt_err, 1);
        chk("R7 no writes", wcnt, 0);

        // scenario: junk between records
        do_reset();
        send({"x11", crlf}, 0);
        tick(0, 0);
        chk("R2 junk outside record", fmt_err, 1);

        // scenario: termination with bad checksum, then good 32-bit one
        do_reset();
        send(mk(8, 32'h334455, '{}, 0, 1), 0);
        tick(0, 0);
        chk("R9 bad csum no done", done, 0);
        chk("R8 term csum_err", csum_err, 1);
        send(mk(7, 32'hDEADBEEF, '{}, 1, 0), 0);
        tick(0, 0);
        chk("R9 done after S7", done, 1);
        chk("R9 entry after S7", entry_addr, 32'hDEADBEEF);
        repeat (3) tick(0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule